// File: doc/BRIEF.md
# Byte SRAM with Content-Status Flags

This block is a 32-byte storage array built from an address decoder, a bank of byte rows and a read multiplexer. A 5-bit offset selects one byte, and each access moves exactly one byte. Within the system map the array answers to byte addresses 0x8000 to 0x801F; the block itself sees only the offset. Writes and reads run on a two-phase non-overlapping clock. Each phase comes with its complement, and the block uses the complement to confirm that the other phase is inactive.

The block also watches the whole array at all times and reduces it to four status flags. One flag reports an all-zero array. One reports an all-ones array. The other two report the split patterns: in one, the lower sixteen bytes are all ones and the upper sixteen are all zeros; in the other, the halves are the other way round. The flags are combinational functions of the stored contents, so they follow any write within the same phase.

Top module: `byte_sram_flags`

## Requirements
- R1: While `rst_n` is low, every byte is cleared to 0x00, `dout` is 0x00 and only `flag_zero` is high. Reading any byte after reset returns 0x00.
- R2: A write fires at the rising edge of `phi2` when `wr` is high and `phi1_b` is high. It stores `din` into byte `addr` and leaves every other byte unchanged.
- R3: A read fires at the rising edge of `phi1` when `rd` is high, `wr` is low and `phi2_b` is high. It loads byte `addr` into `dout`, and the value is visible once that `phi1` pulse ends.
- R4: When `rd` is low at a `phi1` rising edge, `dout` keeps its previous value, whatever `addr` holds.
- R5: When `rd` and `wr` are both high, the write takes place and `dout` keeps its previous value.
- R6: `flag_zero` is high exactly when all 256 stored bits are 0.
- R7: `flag_ones` is high exactly when all 256 stored bits are 1.
- R8: `flag_lo_ones` is high exactly when bytes 0 to 15 are all 0xFF and bytes 16 to 31 are all 0x00.
- R9: `flag_hi_ones` is high exactly when bytes 0 to 15 are all 0x00 and bytes 16 to 31 are all 0xFF.
- R10: At most one of the four flags is high at any time. The flags reflect a write before the next `phi1` rising edge.
- R11: All 32 offsets, from 0 to 31, select distinct bytes. A unique value written to each one reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of the array and the output |
| phi1 | input | 1 | Read phase clock |
| phi1_b | input | 1 | Complement of phi1 |
| phi2 | input | 1 | Write phase clock |
| phi2_b | input | 1 | Complement of phi2 |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request; wins over rd |
| addr | input | 5 | Byte offset 0 to 31 |
| din | input | 8 | Write data |
| dout | output | 8 | Last byte read; held between reads |
| flag_zero | output | 1 | Whole array is zero |
| flag_ones | output | 1 | Whole array is ones |
| flag_lo_ones | output | 1 | Lower half ones, upper half zeros |
| flag_hi_ones | output | 1 | Lower half zeros, upper half ones |

## Verification
The hardest states to reach are the two split patterns. Each needs 32 writes to line up, and a single wrong bit in any byte must drop the flag. The stimulus first fills the array with ones. It then clears the lower half one byte at a time and checks after every write that no flag is high until the sixteenth byte lands, at which point the upper-ones flag must rise. It reaches the opposite split the same way, starting from a fully cleared array. The read-and-write collision is driven on purpose so that it can be seen that the output holds while the stored byte changes.

// File: rtl/sram_flag_pkg.sv
`timescale 1ns/1ps
package sram_flag_pkg;

  typedef struct packed {
    logic hi_ones;
    logic lo_ones;
    logic ones;
    logic zero;
  } flag_t;

  // Combine half-array uniformity into the four status flags.
  function automatic flag_t classify(input logic lo_zero, input logic lo_one,
                                     input logic hi_zero, input logic hi_one);
    flag_t f;
    f.zero    = lo_zero & hi_zero;
    f.ones    = lo_one  & hi_one;
    f.lo_ones = lo_one  & hi_zero;
    f.hi_ones = lo_zero & hi_one;
    return f;
  endfunction

  // True when every bit of a word is one.
  function automatic logic word_all_set(input logic [63:0] w, input int unsigned width);
    logic r;
    r = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < width && !w[i]) r = 1'b0;
    end
    return r;
  endfunction

  // True when every bit of a word is zero.
  function automatic logic word_all_clear(input logic [63:0] w, input int unsigned width);
    logic r;
    r = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < width && w[i]) r = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/sram_addr_dec.sv
`timescale 1ns/1ps
module sram_addr_dec #(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [DEPTH-1:0]  sel
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    assign sel[i] = en && (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/sram_row_array.sv
`timescale 1ns/1ps
module sram_row_array
  import sram_flag_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8
) (
  input  logic                          phi2,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              sel,
  input  logic [DATA_W-1:0]             din,
  output logic [DEPTH-1:0][DATA_W-1:0]  mem_q,
  output logic [DEPTH-1:0]              row_zero,
  output logic [DEPTH-1:0]              row_one
);

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [DATA_W-1:0] q;

    always_ff @(posedge phi2 or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (sel[r]) q <= din;
    end

    assign mem_q[r]    = q;
    assign row_zero[r] = word_all_clear(64'(q), DATA_W);
    assign row_one[r]  = word_all_set(64'(q), DATA_W);
  end

endmodule

// File: rtl/sram_read_port.sv
`timescale 1ns/1ps
module sram_read_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic                          phi1,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]  mem_q,
  output logic [DATA_W-1:0]             mux_word,
  output logic [DATA_W-1:0]             dout
);

  assign mux_word = mem_q[addr];

  always_ff @(posedge phi1 or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= mux_word;
  end

endmodule

// File: rtl/sram_flag_reduce.sv
`timescale 1ns/1ps
module sram_flag_reduce
  import sram_flag_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic [DEPTH-1:0] row_zero,
  input  logic [DEPTH-1:0] row_one,
  output flag_t            flags
);

  localparam int HALF = DEPTH / 2;

  logic lo_zero, lo_one, hi_zero, hi_one;

  assign lo_zero = &row_zero[HALF-1:0];
  assign lo_one  = &row_one[HALF-1:0];
  assign hi_zero = &row_zero[DEPTH-1:HALF];
  assign hi_one  = &row_one[DEPTH-1:HALF];

  assign flags = classify(lo_zero, lo_one, hi_zero, hi_one);

endmodule

// File: rtl/byte_sram_flags.sv
`timescale 1ns/1ps
module byte_sram_flags
  import sram_flag_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              rst_n,
  input  logic              phi1,
  input  logic              phi1_b,
  input  logic              phi2,
  input  logic              phi2_b,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              flag_zero,
  output logic              flag_ones,
  output logic              flag_lo_ones,
  output logic              flag_hi_ones
);

  localparam int DEPTH = 1 << ADDR_W;

  // Named internal events for the checker.
  logic                         wr_fire;
  logic                         rd_fire;
  logic [DEPTH-1:0]             row_sel;
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]             row_zero;
  logic [DEPTH-1:0]             row_one;
  logic [DATA_W-1:0]            mux_word;
  flag_t                        flags;

  // Write only while the read phase is idle; write wins over read.
  assign wr_fire = wr && phi1_b;
  assign rd_fire = rd && !wr && phi2_b;

  sram_addr_dec #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
    .addr (addr),
    .en   (wr_fire),
    .sel  (row_sel)
  );

  sram_row_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rows (
    .phi2     (phi2),
    .rst_n    (rst_n),
    .sel      (row_sel),
    .din      (din),
    .mem_q    (mem_q),
    .row_zero (row_zero),
    .row_one  (row_one)
  );

  sram_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .phi1     (phi1),
    .rst_n    (rst_n),
    .load     (rd_fire),
    .addr     (addr),
    .mem_q    (mem_q),
    .mux_word (mux_word),
    .dout     (dout)
  );

  sram_flag_reduce #(.DEPTH(DEPTH)) u_flags (
    .row_zero (row_zero),
    .row_one  (row_one),
    .flags    (flags)
  );

  assign flag_zero    = flags.zero;
  assign flag_ones    = flags.ones;
  assign flag_lo_ones = flags.lo_ones;
  assign flag_hi_ones = flags.hi_ones;

endmodule

// File: rtl/sram_flag_chk.sv
`timescale 1ns/1ps
module sram_flag_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input logic                         rst_n,
  input logic                         phi1,
  input logic                         phi2,
  input logic                         rd,
  input logic                         wr,
  input logic [ADDR_W-1:0]            addr,
  input logic [DATA_W-1:0]            din,
  input logic [DATA_W-1:0]            dout,
  input logic                         flag_zero,
  input logic                         flag_ones,
  input logic                         flag_lo_ones,
  input logic                         flag_hi_ones,
  input logic                         wr_fire,
  input logic                         rd_fire,
  input logic [DEPTH-1:0][DATA_W-1:0] mem_q,
  input logic [DATA_W-1:0]            mux_word
);

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  // Capture each write at phi2 and confirm it landed by the next phi1.
  always_ff @(posedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pend      <= wr_fire;
      pend_addr <= addr;
      pend_data <= din;
    end
  end

  always @(posedge phi1) begin
    if (rst_n && pend) begin
      p_write_store_r2: assert (mem_q[pend_addr] == pend_data)
        else $error("write did not store");
    end
  end

  p_reset_clear_r1: assert property (@(posedge phi1)
    !rst_n |-> (dout == '0 && flag_zero && mem_q == '0));

  p_read_load_r3: assert property (@(posedge phi1) disable iff (!rst_n)
    rd_fire |=> dout == $past(mux_word));

  p_idle_hold_r4: assert property (@(posedge phi1) disable iff (!rst_n)
    !rd |=> $stable(dout));

  p_collide_hold_r5: assert property (@(posedge phi1) disable iff (!rst_n)
    (rd && wr) |=> $stable(dout));

  p_zero_flag_r6: assert property (@(posedge phi1) disable iff (!rst_n)
    flag_zero == (mem_q == '0));

  p_ones_flag_r7: assert property (@(posedge phi1) disable iff (!rst_n)
    flag_ones == (&mem_q));

  p_flags_excl_r10: assert property (@(posedge phi1) disable iff (!rst_n)
    $onehot0({flag_hi_ones, flag_lo_ones, flag_ones, flag_zero}));

endmodule

bind byte_sram_flags sram_flag_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .DEPTH  (1 << ADDR_W)
) u_chk (
  .rst_n        (rst_n),
  .phi1         (phi1),
  .phi2         (phi2),
  .rd           (rd),
  .wr           (wr),
  .addr         (addr),
  .din          (din),
  .dout         (dout),
  .flag_zero    (flag_zero),
  .flag_ones    (flag_ones),
  .flag_lo_ones (flag_lo_ones),
  .flag_hi_ones (flag_hi_ones),
  .wr_fire      (wr_fire),
  .rd_fire      (rd_fire),
  .mem_q        (mem_q),
  .mux_word     (mux_word)
);

// File: tb/test_byte_sram_flags.sv
`timescale 1ns/1ps
module test_byte_sram_flags;

  logic       rst_n;
  logic       phi1, phi2;
  logic       phi1_b, phi2_b;
  logic       rd, wr;
  logic [4:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic       flag_zero, flag_ones, flag_lo_ones, flag_hi_ones;

  assign phi1_b = ~phi1;
  assign phi2_b = ~phi2;

  byte_sram_flags i_byte_sram_flags (
    .rst_n        (rst_n),
    .phi1         (phi1),
    .phi1_b       (phi1_b),
    .phi2         (phi2),
    .phi2_b       (phi2_b),
    .rd           (rd),
    .wr           (wr),
    .addr         (addr),
    .din          (din),
    .dout         (dout),
    .flag_zero    (flag_zero),
    .flag_ones    (flag_ones),
    .flag_lo_ones (flag_lo_ones),
    .flag_hi_ones (flag_hi_ones)
  );

  // 4 ns frame (250 MHz): phi1 pulse, gap, phi2 pulse, gap.
  initial begin
    phi1 = 1'b0;
    phi2 = 1'b0;
    forever begin
      #0.5 phi1 = 1'b1;
      #1   phi1 = 1'b0;
      #1   phi2 = 1'b1;
      #1   phi2 = 1'b0;
      #0.5;
    end
  end

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] model [32];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Expected flags {hi_ones, lo_ones, ones, zero} from the bench model.
  function automatic logic [3:0] exp_flags();
    bit lz = 1, lo = 1, hz = 1, ho = 1;
    for (int i = 0; i < 16; i++) begin
      if (model[i] != 8'h00) lz = 0;
      if (model[i] != 8'hFF) lo = 0;
    end
    for (int i = 16; i < 32; i++) begin
      if (model[i] != 8'h00) hz = 0;
      if (model[i] != 8'hFF) ho = 0;
    end
    return {lz & ho, lo & hz, lo & ho, lz & hz};
  endfunction

  task automatic check_flags(input string req);
    logic [3:0] act, e;
    act = {flag_hi_ones, flag_lo_ones, flag_ones, flag_zero};
    e   = exp_flags();
    check(act == e, req, act, e);
    check($countones(act) <= 1, "R10", act, e);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge phi2); #0.2;
    rd = 0; wr = 1; addr = a; din = d;
    @(negedge phi2); #0.2;
    wr = 0;
    model[a] = d;
  endtask

  // Driver: push the expected byte; the monitor pops it.
  task automatic do_read(input logic [4:0] a, input string req);
    @(negedge phi2); #0.2;
    rd = 1; wr = 0; addr = a;
    exp_q.push_back(model[a]);
    tag_q.push_back(req);
    @(negedge phi2); #0.2;
    rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge phi2);
    #0.2;
  endtask

  // Monitor: a read is committed at phi1 rise, result visible at phi1 fall.
  initial begin
    bit fire;
    forever begin
      @(posedge phi1);
      fire = rd && !wr && rst_n;
      @(negedge phi1);
      if (fire) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", dout, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dout == e, t, dout, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    rst_n = 0; rd = 0; wr = 0; addr = '0; din = '0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;

    // R1: reset state
    idle(3);
    check(dout == 8'h00, "R1", dout, 0);
    check({flag_hi_ones, flag_lo_ones, flag_ones, flag_zero} == 4'b0001, "R1",
          {flag_hi_ones, flag_lo_ones, flag_ones, flag_zero}, 4'b0001);
    rst_n = 1;
    do_read(0, "R1");
    do_read(31, "R1");

    // R2/R3: single write then reads of it and its neighbour
    do_write(3, 8'hA5);
    check_flags("R6");
    do_read(3, "R3");
    do_read(4, "R2");
    do_read(3, "R3");

    // R4: idle with a changing address keeps dout
    held = dout;
    addr = 4;
    idle(3);
    check(dout == held, "R4", dout, held);
    addr = 0;
    idle(2);
    check(dout == held, "R4", dout, held);

    // R5: read and write together
    held = dout;
    @(negedge phi2); #0.2;
    rd = 1; wr = 1; addr = 5; din = 8'h3C;
    @(negedge phi2); #0.2;
    rd = 0; wr = 0;
    model[5] = 8'h3C;
    check(dout == held, "R5", dout, held);
    do_read(5, "R5");

    // R11: every offset distinct
    for (int i = 0; i < 32; i++) do_write(5'(i), 8'(i * 37 + 11));
    check_flags("R10");
    for (int i = 0; i < 32; i++) do_read(5'(i), "R11");

    // R7: all ones, with a one-bit miss just before
    for (int i = 0; i < 31; i++) do_write(5'(i), 8'hFF);
    do_write(31, 8'hFE);
    check_flags("R7");
    do_write(31, 8'hFF);
    check_flags("R7");
    do_read(31, "R7");

    // R9: clear lower half byte by byte
    for (int i = 0; i < 16; i++) begin
      do_write(5'(i), 8'h00);
      check_flags("R9");
    end
    check(flag_hi_ones == 1'b1, "R9", flag_hi_ones, 1);

    // R6: clear upper half to reach all zeros
    for (int i = 16; i < 32; i++) do_write(5'(i), 8'h00);
    check_flags("R6");
    check(flag_zero == 1'b1, "R6", flag_zero, 1);

    // R8: set lower half byte by byte
    for (int i = 0; i < 16; i++) begin
      do_write(5'(i), 8'hFF);
      check_flags("R8");
    end
    check(flag_lo_ones == 1'b1, "R8", flag_lo_ones, 1);
    do_write(16, 8'h01);
    check_flags("R8");
    check(flag_lo_ones == 1'b0, "R8", flag_lo_ones, 0);

    idle(3);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    finish_run();
  end

endmodule